// File: doc/BRIEF.md
# SHA3-256 Byte Padder and Rate-Block Packer

This block sits in front of a multi-block SHA3-256 absorb engine. It accepts a message as a stream of bytes with a valid/ready handshake and an end-of-message flag. It gathers the bytes into rate blocks of `RATE_BYTES` bytes, which is 136 bytes (1088 bits) by default. The earliest byte of each block lands in the least significant byte lane.

When the message ends, the packer applies the complete SHA3-256 padding itself. It merges the 0x06 domain suffix and the pad10*1 closing bit into the final block. If the message fills its last block exactly, it emits an extra block that holds padding only. The downstream engine therefore only has to XOR each block into its state and permute.

Each finished block is held on the output with a valid flag and a last flag until the engine takes it. While a block is waiting, no input bytes are accepted. A beat may be marked as carrying no byte. Such a beat lets a message end without a data byte, and it is how an empty message is hashed.

The controller has four states:
- `ST_FILL` accepts bytes.
- `ST_DATA` holds a full data block that is not the last one.
- `ST_DATA_XTRA` holds a full data block whose message ended exactly on the boundary.
- `ST_FINAL` holds the padded last block.

The transitions are:
- FILL→DATA: the block fills without end-of-message.
- FILL→DATA_XTRA: the block fills on the end-of-message byte.
- FILL→FINAL: the message ends with room left in the block.
- DATA→FILL: the held block is accepted.
- DATA_XTRA→FINAL: the held block is accepted, and the padding-only block is loaded in the same cycle.
- FINAL→FILL: the last block is accepted, and the register is cleared.

Top module: `sha3_pad_packer`

## Requirements
- R1: A block is `RATE_BYTES` bytes wide (default 136, giving 1088 bits). The k-th byte of a block, counted in arrival order from 0, occupies bits [8k+7:8k] of `out_block`.
- R2: In the final block, 0x06 is XORed into the byte position equal to the number of message bytes that block holds. 0x80 is XORed into byte `RATE_BYTES-1`. All other unused bytes are zero.
- R3: When the message leaves exactly one free byte in its final block, byte `RATE_BYTES-1` of that block reads 0x86.
- R4: When the message length is a multiple of `RATE_BYTES`, including zero, the last data block goes out with `out_last`=0. It is followed by a block that has 0x06 in byte 0, 0x80 in byte `RATE_BYTES-1`, zeros elsewhere, and `out_last`=1.
- R5: `out_last` is 1 with the final padded block of a message and with no other block.
- R6: A block transfers only on a cycle where `out_valid` and `out_ready` are both 1. While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_block` and `out_last` hold their values.
- R7: `in_ready` is 0 whenever `out_valid` is 1. A beat offered while `in_ready`=0 is not consumed and is not lost.
- R8: An asynchronous active-low reset empties the packer: `out_valid`=0, `out_block`=0 and `in_ready`=1, and any partly filled block is discarded.
- R9: In the cycle after the last block is accepted, `out_valid`=0, `in_ready`=1 and `out_block`=0, and a new message starts at byte 0.
- R10: A beat with `in_nodata`=1 contributes no byte, and its `in_byte` is ignored. With `in_last`=0 the beat has no effect on the output. With `in_last`=1 it ends the message after the bytes already given, which allows an empty message.
- R11: With the default rate, an 800-byte message gives exactly 6 blocks. The first five are full data blocks, and the sixth holds the remaining 120 bytes followed by the padding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Packer accepts a beat this cycle |
| in_byte | input | 8 | Message byte of the beat |
| in_nodata | input | 1 | Beat carries no byte (in_byte ignored) |
| in_last | input | 1 | Beat ends the message |
| out_valid | output | 1 | A block is presented |
| out_ready | input | 1 | Downstream takes the presented block |
| out_block | output | RATE_BYTES*8 | Packed block, byte 0 in bits [7:0] |
| out_last | output | 1 | Presented block is the final padded block |

## Verification
The bench builds two copies of the block. The first uses `RATE_BYTES`=4, which makes each block only four bytes wide. With that rate, a sweep over every message length from 0 to 13 crosses every final-block fill level, including the one-free-byte 0x86 case, the exact-boundary extra block and the empty message. Each length is sent in three termination styles, and the outputs are compared under pseudo-random backpressure on both sides. The second copy uses the default 136-byte rate. It is driven with 800-, 136- and 135-byte messages, so the full-width byte placement and the six-block split are checked at the real block size.

// File: rtl/sha3pad_pkg.sv
package sha3pad_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_FILL      = 2'd0,   // accepting message bytes
        ST_DATA      = 2'd1,   // full data block held, more follows
        ST_DATA_XTRA = 2'd2,   // full data block held, padding-only block follows
        ST_FINAL     = 2'd3    // padded last block held
    } pad_state_e;

    // SHA3 domain suffix and closing pad bit, as byte values
    localparam logic [7:0] SUFFIX_BYTE = 8'h06;
    localparam logic [7:0] PAD_END     = 8'h80;

endpackage

// File: rtl/sha3pad_ctrl.sv
module sha3pad_ctrl
    import sha3pad_pkg::*;
#(
    parameter int RATE_BYTES = 136,
    parameter int IDX_W      = $clog2(RATE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_nodata,
    input  logic             in_last,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_last,
    output logic             lane_clr,
    output logic             lane_padonly,
    output logic             lane_wr,
    output logic [IDX_W-1:0] wr_idx,
    output logic             pad_en,
    output logic [IDX_W-1:0] pad_pos
);

    localparam logic [IDX_W-1:0] RATE_CNT = IDX_W'(RATE_BYTES);

    pad_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] fill_pos;
    logic             beat;
    logic             blk_full;

    // A beat is taken only while filling
    assign beat     = in_valid && (state_q == ST_FILL);
    // Bytes present in the block once this beat is applied
    assign fill_pos = idx_q + {{(IDX_W-1){1'b0}}, ~in_nodata};
    assign blk_full = (fill_pos == RATE_CNT);

    // Next-state and byte-position logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_FILL: begin
                if (beat) begin
                    idx_d = (blk_full || in_last) ? '0 : fill_pos;
                    if (blk_full)
                        state_d = in_last ? ST_DATA_XTRA : ST_DATA;
                    else if (in_last)
                        state_d = ST_FINAL;
                end
            end
            ST_DATA:      if (out_ready) state_d = ST_FILL;
            ST_DATA_XTRA: if (out_ready) state_d = ST_FINAL;
            ST_FINAL:     if (out_ready) state_d = ST_FILL;
            default:      state_d = ST_FILL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs and lane controls
    always_comb begin
        in_ready     = 1'b0;
        out_valid    = 1'b0;
        out_last     = 1'b0;
        lane_clr     = 1'b0;
        lane_padonly = 1'b0;
        lane_wr      = 1'b0;
        pad_en       = 1'b0;
        wr_idx       = idx_q;
        pad_pos      = fill_pos;
        unique case (state_q)
            ST_FILL: begin
                in_ready = 1'b1;
                lane_wr  = beat && !in_nodata;
                pad_en   = beat && in_last && !blk_full;
            end
            ST_DATA: begin
                out_valid = 1'b1;
                lane_clr  = out_ready;
            end
            ST_DATA_XTRA: begin
                out_valid    = 1'b1;
                lane_padonly = out_ready;
            end
            ST_FINAL: begin
                out_valid = 1'b1;
                out_last  = 1'b1;
                lane_clr  = out_ready;
            end
            default: ;
        endcase
    end

    // R1: the fill position never reaches the block size between beats
    p_idx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < RATE_CNT);

    // R6: a refused block stays presented with the same last flag
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_last)));

    // R7: a stalled input beat does not advance the fill position
    p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_valid) |=> $stable(idx_q));

    // R4: leaving the boundary state always yields a final block
    p_xtra_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA_XTRA && out_ready) |=> (out_valid && out_last));

    // R9: after the last block goes, the packer is empty and ready
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && idx_q == '0));

endmodule

// File: rtl/sha3pad_lane.sv
module sha3pad_lane
    import sha3pad_pkg::*;
#(
    parameter int LANE       = 0,
    parameter int RATE_BYTES = 136,
    parameter int IDX_W      = $clog2(RATE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             padonly,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic             pad_en,
    input  logic [IDX_W-1:0] pad_pos,
    output logic [7:0]       q
);

    localparam logic [IDX_W-1:0] LANE_IDX = IDX_W'(LANE);
    localparam bit               IS_HEAD  = (LANE == 0);
    localparam bit               IS_TAIL  = (LANE == RATE_BYTES - 1);
    localparam logic [7:0]       PADONLY_VAL =
        (IS_HEAD ? SUFFIX_BYTE : 8'h00) ^ (IS_TAIL ? PAD_END : 8'h00);

    logic [7:0] lane_q, lane_d;

    always_comb begin
        lane_d = lane_q;
        if (clr) begin
            lane_d = '0;
        end else if (padonly) begin
            lane_d = PADONLY_VAL;
        end else begin
            if (wr_en && wr_idx == LANE_IDX)
                lane_d = wr_byte;
            if (pad_en && pad_pos == LANE_IDX)
                lane_d = lane_d ^ SUFFIX_BYTE;
            if (pad_en && IS_TAIL)
                lane_d = lane_d ^ PAD_END;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign q = lane_q;

endmodule

// File: rtl/sha3_pad_packer.sv
module sha3_pad_packer
    import sha3pad_pkg::*;
#(
    parameter  int RATE_BYTES = 136,
    localparam int BLOCK_W    = RATE_BYTES * 8,
    localparam int IDX_W      = $clog2(RATE_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [7:0]         in_byte,
    input  logic               in_nodata,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [BLOCK_W-1:0] out_block,
    output logic               out_last
);

    logic             lane_clr;
    logic             lane_padonly;
    logic             lane_wr;
    logic [IDX_W-1:0] wr_idx;
    logic             pad_en;
    logic [IDX_W-1:0] pad_pos;

    sha3pad_ctrl #(
        .RATE_BYTES (RATE_BYTES),
        .IDX_W      (IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_nodata    (in_nodata),
        .in_last      (in_last),
        .out_ready    (out_ready),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_last     (out_last),
        .lane_clr     (lane_clr),
        .lane_padonly (lane_padonly),
        .lane_wr      (lane_wr),
        .wr_idx       (wr_idx),
        .pad_en       (pad_en),
        .pad_pos      (pad_pos)
    );

    // One byte lane per block position
    for (genvar g = 0; g < RATE_BYTES; g++) begin : g_lane
        sha3pad_lane #(
            .LANE       (g),
            .RATE_BYTES (RATE_BYTES),
            .IDX_W      (IDX_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (lane_clr),
            .padonly (lane_padonly),
            .wr_en   (lane_wr),
            .wr_idx  (wr_idx),
            .wr_byte (in_byte),
            .pad_en  (pad_en),
            .pad_pos (pad_pos),
            .q       (out_block[8*g +: 8])
        );
    end

    // R6: block contents hold while the block is refused
    p_block_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_block));

    // R2: every final block carries the closing pad bit in its top byte
    p_tail_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> out_block[BLOCK_W-1]);

    // R9: the block register is empty once the last block is taken
    p_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (out_block == '0 && !out_valid));

endmodule

// File: tb/test_sha3_pad_packer.sv
module test_sha3_pad_packer;

    localparam int SR = 4;
    localparam int SW = SR * 8;
    localparam int BR = 136;
    localparam int BW = BR * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    // small-rate instance
    logic          s_in_valid = 0, s_in_nodata = 0, s_in_last = 0, s_out_ready = 0;
    logic [7:0]    s_in_byte = 0;
    logic          s_in_ready, s_out_valid, s_out_last;
    logic [SW-1:0] s_out_block;

    // default-rate instance
    logic          b_in_valid = 0, b_in_nodata = 0, b_in_last = 0, b_out_ready = 1;
    logic [7:0]    b_in_byte = 0;
    logic          b_in_ready, b_out_valid, b_out_last;
    logic [BW-1:0] b_out_block;

    sha3_pad_packer #(.RATE_BYTES(SR)) i_sha3_pad_packer (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s_in_valid), .in_ready(s_in_ready), .in_byte(s_in_byte),
        .in_nodata(s_in_nodata), .in_last(s_in_last),
        .out_valid(s_out_valid), .out_ready(s_out_ready),
        .out_block(s_out_block), .out_last(s_out_last));

    sha3_pad_packer i_sha3_pad_packer_full (
        .clk(clk), .rst_n(rst_n),
        .in_valid(b_in_valid), .in_ready(b_in_ready), .in_byte(b_in_byte),
        .in_nodata(b_in_nodata), .in_last(b_in_last),
        .out_valid(b_out_valid), .out_ready(b_out_ready),
        .out_block(b_out_block), .out_last(b_out_last));

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input int m, input int i);
        return 8'((m * 29 + i * 7 + 3) % 256);
    endfunction

    // Expected block b of a message of len bytes at rate r (R1, R2, R3, R4)
    function automatic logic [BW-1:0] exp_block(input int r, input int len,
                                                input int m, input int b);
        logic [BW-1:0] v = '0;
        for (int k = 0; k < r; k++) begin
            if (b * r + k < len) v[8*k +: 8] = dbyte(m, b * r + k);
        end
        if (b == len / r) begin
            v[8*(len % r) +: 8] = v[8*(len % r) +: 8] ^ 8'h06;
            v[8*(r-1) +: 8]     = v[8*(r-1) +: 8] ^ 8'h80;
        end
        return v;
    endfunction

    // expected small-instance stream
    logic [SW-1:0] exp_blk[$];
    bit            exp_last[$];
    string         exp_tag[$];
    bit            rx_stop = 0;

    task automatic push_expected(input int len, input int m, input int mode);
        int nb = len / SR + 1;
        for (int b = 0; b < nb; b++) begin
            string t;
            if (b < nb - 1)                 t = "R1";
            else if (len % SR == 0)         t = "R4";
            else if (len % SR == SR - 1)    t = "R3";
            else                            t = "R2";
            if (mode != 0) t = {t, "/R10"};
            exp_blk.push_back(SW'(exp_block(SR, len, m, b)));
            exp_last.push_back(b == nb - 1);
            exp_tag.push_back(t);
        end
    endtask

    task automatic s_beat(input logic [7:0] d, input logic nd, input logic lst);
        @(negedge clk);
        s_in_valid = 1; s_in_byte = d; s_in_nodata = nd; s_in_last = lst;
        forever begin
            #2;
            if (s_in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    // mode 0: last on final byte; 1: no-data end beat (R10);
    // 2: last on final byte with no-data beats mixed in (R10)
    task automatic s_message(input int len, input int m, input int mode);
        push_expected(len, m, mode);
        for (int i = 0; i < len; i++) begin
            if ((i + m) % 4 == 3) begin
                @(negedge clk);
                s_in_valid = 0;
            end
            s_beat(dbyte(m, i), 1'b0, (mode != 1) && (i == len - 1));
            if (mode == 2 && i % 3 == 1 && i != len - 1)
                s_beat(8'hFF, 1'b1, 1'b0);
        end
        if (mode == 1) s_beat(8'hA5, 1'b1, 1'b1);
        @(negedge clk);
        s_in_valid = 0;
    endtask

    task automatic small_rx();
        logic [15:0]   lfsr = 16'hACE1;
        bit            hold = 0, want_clear = 0, rdy;
        logic [SW-1:0] hb = '0;
        logic          hl = 0;
        while (!rx_stop) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rdy = lfsr[0] | lfsr[3];
            s_out_ready = rdy;
            #2;
            if (want_clear) begin
                // R9: empty and ready right after the last block
                check(s_out_block == '0 && s_in_ready && !s_out_valid, "R9",
                      "state after last block", {s_out_block, s_in_ready, s_out_valid},
                      {{SW{1'b0}}, 2'b10});
                want_clear = 0;
            end
            if (hold) begin
                // R6: refused block held unchanged
                check(s_out_valid && s_out_block == hb && s_out_last == hl, "R6",
                      "held block", {s_out_valid, s_out_last, s_out_block},
                      {1'b1, hl, hb});
            end
            if (s_out_valid) begin
                // R7: input stalled while a block waits
                check(!s_in_ready, "R7", "in_ready while block pending",
                      BW'(s_in_ready), '0);
            end
            if (s_out_valid && rdy) begin
                if (exp_blk.size() == 0) begin
                    check(0, "R5", "unexpected block", s_out_block, '0);
                end else begin
                    logic [SW-1:0] e  = exp_blk.pop_front();
                    bit            el = exp_last.pop_front();
                    string         t  = exp_tag.pop_front();
                    check(s_out_block == e, t, "block contents", s_out_block, e);
                    check(s_out_last == el, "R5", "last flag", BW'(s_out_last), BW'(el));
                    want_clear = s_out_last;
                end
            end
            hold = s_out_valid && !rdy;
            hb   = s_out_block;
            hl   = s_out_last;
        end
        s_out_ready = 0;
    endtask

    // default-rate instance: always ready downstream, collect blocks
    logic [BW-1:0] big_blk[0:7];
    bit            big_last[0:7];
    int            big_n;

    task automatic b_beat(input logic [7:0] d, input logic lst);
        @(negedge clk);
        b_in_valid = 1; b_in_byte = d; b_in_nodata = 0; b_in_last = lst;
        forever begin
            #2;
            if (b_in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic big_run(input int len, input int m, input string tag);
        int nb = len / BR + 1;
        big_n = 0;
        fork
            begin
                for (int i = 0; i < len; i++) b_beat(dbyte(m, i), i == len - 1);
                @(negedge clk);
                b_in_valid = 0;
            end
            begin
                bit got = 0;
                while (!got) begin
                    @(negedge clk);
                    #2;
                    if (b_out_valid) begin
                        if (big_n < 8) begin
                            big_blk[big_n]  = b_out_block;
                            big_last[big_n] = b_out_last;
                        end
                        big_n++;
                        got = b_out_last || big_n >= 8;
                    end
                end
            end
        join
        check(big_n == nb, tag, "block count", BW'(big_n), BW'(nb));
        for (int b = 0; b < nb && b < big_n; b++) begin
            check(big_blk[b] == exp_block(BR, len, m, b), tag, "full-rate block",
                  big_blk[b], exp_block(BR, len, m, b));
            check(big_last[b] == (b == nb - 1), "R5", "full-rate last flag",
                  BW'(big_last[b]), BW'(b == nb - 1));
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int m = 0;
        // R8: state under reset
        #3;
        check(!s_out_valid && s_in_ready && s_out_block == '0, "R8", "reset state",
              {s_out_valid, s_in_ready, s_out_block}, {2'b01, {SW{1'b0}}});
        check(!b_out_valid && b_in_ready && b_out_block == '0, "R8", "reset state full",
              b_out_block, '0);
        repeat (2) @(negedge clk);
        rst_n = 1;

        fork small_rx(); join_none

        // length sweep at rate 4 (R1, R2, R3, R4, R10)
        for (int len = 0; len <= 3 * SR + 1; len++) begin
            for (int mode = 0; mode < 3; mode++) begin
                if (len == 0 && mode != 1) continue;
                s_message(len, m, mode);
                m++;
            end
        end
        wait (exp_blk.size() == 0);
        repeat (4) @(negedge clk);

        // R8: reset in the middle of a block discards it
        s_beat(8'h5A, 1'b0, 1'b0);
        s_beat(8'hC3, 1'b0, 1'b0);
        @(negedge clk);
        s_in_valid = 0;
        rst_n = 0;
        #1;
        check(!s_out_valid && s_in_ready && s_out_block == '0, "R8", "async reset mid block",
              s_out_block, '0);
        @(negedge clk);
        rst_n = 1;
        s_message(3, m, 0);
        m++;
        wait (exp_blk.size() == 0);
        repeat (4) @(negedge clk);
        rx_stop = 1;
        repeat (4) @(negedge clk);

        // default rate: R11 six-block split, R4 boundary, R3 0x86 byte
        big_run(800, 91, "R11");
        check(big_blk[5][8*120 +: 8] == 8'h06 && big_blk[5][8*135 +: 8] == 8'h80,
              "R11", "sixth block pad bytes", big_blk[5], exp_block(BR, 800, 91, 5));
        big_run(136, 92, "R4");
        big_run(135, 93, "R3");
        check(big_blk[0][8*135 +: 8] == 8'h86, "R3", "merged pad byte",
              BW'(big_blk[0][8*135 +: 8]), BW'(8'h86));

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule